// File: doc/BRIEF.md
# LFSR Divide-by-13 Pulse Generator

This block divides its clock by thirteen. It does not count with a binary adder. A four-bit Galois shift register with XNOR feedback steps through a fixed run of states. The register is loaded with a start state. A comparator watches for the state that lies twelve steps further on. When that state appears, the register reloads the start state and a registered strobe goes high for exactly one clock. The strobe therefore repeats every thirteen input clocks.

The register width, tap mask, start state and divide ratio are parameters. The match state is worked out at elaboration by stepping the start state forward `DIV-1` times, so no table has to be kept by hand. The feedback is the trinomial x^4+x+1 in XNOR form. The state that form cannot leave is all ones, so the start state must never be all ones.

Top module: `lfsr_div13`

## Requirements
- R1: While `rst` is high at a rising edge, `pulse_o` is 0 after that edge, and it remains 0 in the first cycle after `rst` falls.
- R2: After `rst` is released, the first high cycle of `pulse_o` follows the `DIV`-th rising edge with `rst` low (13 in the default build), and it is the first high cycle since the release.
- R3: The rising edges of consecutive `pulse_o` highs are exactly `DIV` clocks apart, with no pulse in between.
- R4: Each high of `pulse_o` lasts exactly one clock cycle.
- R5: Asserting `rst` in the middle of a period discards the partial count. The next pulse then follows the `DIV`-th edge after the release, whatever the phase was when reset arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| pulse_o | output | 1 | Registered one-cycle strobe, once per `DIV` clocks |

## Verification
The bench builds two copies of the block. The first uses the defaults: a 4-bit register, start state 0000 and a ratio of 13. That exercises the trinomial taps and the match state twelve steps along the sequence. The second starts from 0110 with a ratio of 7. That moves the computed match state to a different point of the sequence and gives a short period, so many intervals and a mid-period reset at a different phase fall within the same run.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

  localparam int unsigned LFSR_MAX_W = 16;

  // One step of an XNOR-feedback Galois register held in the low w bits.
  function automatic logic [LFSR_MAX_W-1:0] lfsr_step(
    input logic [LFSR_MAX_W-1:0] state,
    input logic [LFSR_MAX_W-1:0] taps,
    input int unsigned           w
  );
    logic [LFSR_MAX_W-1:0] nxt;
    logic                  fb;
    fb     = state[w-1];
    nxt    = '0;
    nxt[0] = fb;
    for (int i = 1; i < LFSR_MAX_W; i++) begin
      if (i < w) begin
        nxt[i] = taps[i] ? ~(state[i-1] ^ fb) : state[i-1];
      end
    end
    return nxt;
  endfunction

  // State reached after 'steps' steps from 'seed'.
  function automatic logic [LFSR_MAX_W-1:0] lfsr_advance(
    input logic [LFSR_MAX_W-1:0] seed,
    input logic [LFSR_MAX_W-1:0] taps,
    input int unsigned           w,
    input int unsigned           steps
  );
    logic [LFSR_MAX_W-1:0] s;
    s = seed;
    for (int unsigned k = 0; k < steps; k++) begin
      s = lfsr_step(s, taps, w);
    end
    return s;
  endfunction

endpackage

// File: rtl/lfsr_div_next.sv
module lfsr_div_next #(
  parameter int unsigned        WIDTH = 4,
  parameter logic [WIDTH-1:0]   TAPS  = 4'b0010
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  logic fb;
  assign fb     = cur[WIDTH-1];
  assign nxt[0] = fb;

  for (genvar gi = 1; gi < WIDTH; gi++) begin : g_bit
    if (TAPS[gi]) begin : g_tap
      assign nxt[gi] = ~(cur[gi-1] ^ fb);
    end else begin : g_pass
      assign nxt[gi] = cur[gi-1];
    end
  end

endmodule

// File: rtl/lfsr_div_match.sv
module lfsr_div_match #(
  parameter int unsigned      WIDTH = 4,
  parameter logic [WIDTH-1:0] MATCH = '0
) (
  input  logic [WIDTH-1:0] cur,
  output logic             hit
);

  assign hit = (cur == MATCH);

endmodule

// File: rtl/lfsr_div13.sv
module lfsr_div13 #(
  parameter int unsigned      WIDTH = 4,
  parameter logic [WIDTH-1:0] TAPS  = 4'b0010,
  parameter logic [WIDTH-1:0] START = 4'b0000,
  parameter int unsigned      DIV   = 13
) (
  input  logic clk,
  input  logic rst,
  output logic pulse_o
);
  import lfsr_div_pkg::*;

  localparam logic [LFSR_MAX_W-1:0] END_WIDE =
    lfsr_advance(LFSR_MAX_W'(START), LFSR_MAX_W'(TAPS), WIDTH, DIV - 1);
  localparam logic [WIDTH-1:0] END_STATE = END_WIDE[WIDTH-1:0];

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;
  logic             hit;

  lfsr_div_next #(
    .WIDTH (WIDTH),
    .TAPS  (TAPS)
  ) u_next (
    .cur (cnt_q),
    .nxt (cnt_nxt)
  );

  lfsr_div_match #(
    .WIDTH (WIDTH),
    .MATCH (END_STATE)
  ) u_match (
    .cur (cnt_q),
    .hit (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= START;
      pulse_o <= 1'b0;
    end else if (hit) begin
      cnt_q   <= START;
      pulse_o <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt;
      pulse_o <= 1'b0;
    end
  end

endmodule

// File: rtl/lfsr_div13_chk.sv
module lfsr_div13_chk #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DIV   = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             pulse,
  input logic [WIDTH-1:0] cnt,
  input logic             hit
);

  localparam int unsigned GW = $clog2(DIV + 2);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (pulse) begin
      gap_q <= GW'(1);
    end else if (gap_q <= GW'(DIV)) begin
      gap_q <= gap_q + GW'(1);
    end
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pulse);                                   // R1
  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    hit |=> pulse);                                           // R2
  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    cnt != '1);                                               // R2
  AST_PERIOD_EXACT: assert property (@(posedge clk) disable iff (rst)
    pulse |-> gap_q == GW'(DIV));                             // R3
  AST_NO_LATE: assert property (@(posedge clk) disable iff (rst)
    gap_q <= GW'(DIV));                                       // R5
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);                                        // R4

endmodule

bind lfsr_div13 lfsr_div13_chk #(
  .WIDTH (WIDTH),
  .DIV   (DIV)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .pulse (pulse_o),
  .cnt   (cnt_q),
  .hit   (hit)
);

// File: tb/lfsr_div13_bench.sv
module lfsr_div13_bench;

  localparam int DIV_A = 13;
  localparam int DIV_B = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pa;
  logic pb;

  always #2 clk = ~clk;

  lfsr_div13 u_lfsr_div13 (
    .clk     (clk),
    .rst     (rst),
    .pulse_o (pa)
  );

  lfsr_div13 #(
    .START (4'b0110),
    .DIV   (DIV_B)
  ) u_lfsr_div13_b (
    .clk     (clk),
    .rst     (rst),
    .pulse_o (pb)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  int  cyc      = 0;
  int  since    = 0;
  int  last_a   = -1;
  int  last_b   = -1;
  bit  mid      = 1'b0;
  bit  prev_a   = 1'b0;
  bit  prev_b   = 1'b0;
  bit  done     = 1'b0;

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s at cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic string pick_tag(input bit in_rst, input int s, input int div,
                                     input bit after_mid, input bit was_high);
    if (in_rst || s <= 1) return "R1 reset state";
    if (was_high)         return "R4 single-cycle width";
    if (after_mid && s <= div) return "R5 restart after mid-period reset";
    if (s <= div)         return "R2 first pulse after release";
    return "R3 steady period";
  endfunction

  task automatic tick();
    logic r;
    logic ea;
    logic eb;
    r = rst;
    @(posedge clk);
    #1;
    cyc++;
    if (r) since = 0;
    else   since++;
    ea = (!r && since > 0 && (since % DIV_A) == 0);
    eb = (!r && since > 0 && (since % DIV_B) == 0);
    check_bit({pick_tag(r, since, DIV_A, mid, prev_a), " (div 13)"}, pa, ea);
    check_bit({pick_tag(r, since, DIV_B, mid, prev_b), " (div 7)"},  pb, eb);
    if (r) begin
      last_a = -1;
      last_b = -1;
    end
    if (pa === 1'b1) begin
      if (last_a >= 0) check_int("R3 interval (div 13)", cyc - last_a, DIV_A);
      last_a = cyc;
    end
    if (pb === 1'b1) begin
      if (last_b >= 0) check_int("R3 interval (div 7)", cyc - last_b, DIV_B);
      last_b = cyc;
    end
    prev_a = (pa === 1'b1);
    prev_b = (pb === 1'b1);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    repeat (100) tick();
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    mid = 1'b1;
    repeat (45) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    repeat (60) tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule